// File: doc/BRIEF.md
# Looping Micro-Sequencer Without an ALU

This block is a program sequencer for a datapath that sits beside it. A program counter addresses a fixed program store. Each stored word carries a field of control signals, and the block presents that field to the datapath while the word is current. The rest of the word tells the sequencer where to go next. It can step on, jump, branch on one of several external condition flags, enter or close a counted loop, call a subroutine, return from one, or stop.

Counted loops and subroutine returns use a small hardware stack. Each stack entry holds a return address and an iteration count. The count is only ever tested against one and decremented, so the sequencer needs no general arithmetic unit. This keeps program control physically apart from the data processing it steers. Loops can be nested as deep as the stack allows.

The program image is a parameter of the top module. A synchronous reset restarts execution at address zero.

Top module: `microseq_top`

## Requirements
- R1: After a cycle with `rst_n` low, `pc_o` is 0 and both `halted_o` and `err_o` are 0.
- R2: A program word is {control[35:16], opcode[15:13], target[12:6], field[5:0]}. The opcodes are 0 step, 1 jump, 2 branch, 3 loop-open, 4 loop-close, 5 call, 6 return and 7 stop. While the block runs, `ctrl_o` equals the control bits of the word at `pc_o`; while it is halted, `ctrl_o` is 0.
- R3: A step word moves `pc_o` to the next address on the next cycle.
- R4: A jump word moves `pc_o` to its target on the next cycle.
- R5: A branch word picks condition flag `field[2:0]` and XORs it with `field[5]`. If the result is 1, `pc_o` goes to the target; otherwise it goes to the next address.
- R6: A loop-open word with a non-zero count in `field` pushes {next address, count} and moves on to the next address. With a count of zero it pushes nothing and jumps to its target.
- R7: A loop-close word whose top-of-stack count is above one decrements that count and jumps back to the stored address. A count of exactly one pops the entry and falls through. As a result, a loop with count N runs its body N times, and nested loops multiply.
- R8: A call word pushes the next address and jumps to its target. A return word pops that entry and continues from the stored address.
- R9: A stop word freezes `pc_o` and sets `halted_o` from the next cycle on.
- R10: A push onto a full stack, or a pop or loop-close on an empty stack, sets `err_o` and `halted_o`. Both stay set until reset, and `pc_o` stays at the faulting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 8 | External condition flags tested by branch words |
| ctrl_o | output | 20 | Control signals of the current word, zero when halted |
| pc_o | output | 7 | Current program counter |
| halted_o | output | 1 | Sequencer stopped |
| err_o | output | 1 | Sticky stack fault |

## Verification
The main program wraps a two-deep inner loop inside a three-deep outer loop. It follows them with a zero-count loop, a call and return, a branch and a jump. The bench follows the whole program counter trace cycle by cycle, so a wrong iteration count, a missed pop or a bad return address each show up as a different address at a known cycle. Running the same program with the condition flags cleared instead of set tells a taken branch from a fall-through, and also exercises an inverted flag select. Two further programs call too deep and return with nothing stacked, to separate the overflow fault from the underflow fault.

// File: rtl/microseq_pkg.sv
// Shared definitions for the looping micro-sequencer.
// Assumes a three-bit opcode field in every program word.
package microseq_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_STEP   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_BRANCH = 3'd2,
        OP_LOOP   = 3'd3,
        OP_ENDLP  = 3'd4,
        OP_CALL   = 3'd5,
        OP_RET    = 3'd6,
        OP_STOP   = 3'd7
    } op_e;
endpackage

// File: rtl/microseq_rom.sv
// Read-only program store, unpacked from a flat parameter image.
// Assumes entry g sits at bits [g*WORD_W +: WORD_W]; read is combinational.
module microseq_rom #(
    parameter int DEPTH  = 128,
    parameter int WORD_W = 36,
    parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0]     addr_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    // unpack each word of the image into the array
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign mem[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    // select the addressed word
    assign word_o = mem[addr_i];
endmodule

// File: rtl/microseq_stack.sv
// Loop-and-return stack: each entry holds a resume address and a count.
// Assumes the caller never asks for push and pop together, and never asks
// for either on a full or empty stack (the caller checks full/empty first).
module microseq_stack #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 6,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              dec_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [PTR_W-1:0]  depth_o
);
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    logic [PTR_W-1:0]  sp_q;
    logic [PTR_W-1:0]  top_idx;

    // index of the top entry (only meaningful when not empty)
    assign top_idx = (sp_q == '0) ? '0 : sp_q - 1'b1;

    // stack pointer: grows on push, shrinks on pop
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= '0;
        else if (push_i) sp_q <= sp_q + 1'b1;
        else if (pop_i)  sp_q <= sp_q - 1'b1;
    end

    // entry storage: write on push, decrement the top count on request
    always_ff @(posedge clk) begin
        if (push_i) begin
            addr_q[sp_q[$clog2(DEPTH)-1:0]] <= push_addr_i;
            cnt_q[sp_q[$clog2(DEPTH)-1:0]]  <= push_cnt_i;
        end else if (dec_i) begin
            cnt_q[top_idx[$clog2(DEPTH)-1:0]] <= cnt_q[top_idx[$clog2(DEPTH)-1:0]] - 1'b1;
        end
    end

    // top-of-stack view and occupancy flags
    assign top_addr_o = addr_q[top_idx[$clog2(DEPTH)-1:0]];
    assign top_cnt_o  = cnt_q[top_idx[$clog2(DEPTH)-1:0]];
    assign empty_o    = (sp_q == '0);
    assign full_o     = (sp_q == PTR_W'(DEPTH));
    assign depth_o    = sp_q;
endmodule

// File: rtl/microseq_next.sv
// Next-address and stack-command decode for one program word.
// Purely combinational; a detected stack fault suppresses all stack commands.
module microseq_next #(
    parameter int ADDR_W  = 7,
    parameter int FIELD_W = 6,
    parameter int COND_W  = 8,
    localparam int SEL_W  = $clog2(COND_W)
) (
    input  microseq_pkg::op_e   op_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [ADDR_W-1:0]   tgt_i,
    input  logic [FIELD_W-1:0]  fld_i,
    input  logic [COND_W-1:0]   cond_i,
    input  logic [ADDR_W-1:0]   top_addr_i,
    input  logic [FIELD_W-1:0]  top_cnt_i,
    input  logic                empty_i,
    input  logic                full_i,
    output logic [ADDR_W-1:0]   next_pc_o,
    output logic                push_o,
    output logic                pop_o,
    output logic                dec_o,
    output logic [FIELD_W-1:0]  push_cnt_o,
    output logic                stop_o,
    output logic                fault_o
);
    import microseq_pkg::*;

    logic [ADDR_W-1:0] seq_pc;
    logic              flag_hit;

    // the address after the current one, and the selected condition
    assign seq_pc   = pc_i + 1'b1;
    assign flag_hit = cond_i[fld_i[SEL_W-1:0]] ^ fld_i[FIELD_W-1];

    // choose next pc and stack commands from the opcode
    always_comb begin
        next_pc_o  = seq_pc;
        push_o     = 1'b0;
        pop_o      = 1'b0;
        dec_o      = 1'b0;
        push_cnt_o = '0;
        stop_o     = 1'b0;
        fault_o    = 1'b0;
        unique case (op_i)
            OP_STEP:   next_pc_o = seq_pc;
            OP_JUMP:   next_pc_o = tgt_i;
            OP_BRANCH: if (flag_hit) next_pc_o = tgt_i;
            OP_LOOP: begin
                if (fld_i == '0) next_pc_o = tgt_i;
                else if (full_i) fault_o = 1'b1;
                else begin
                    push_o     = 1'b1;
                    push_cnt_o = fld_i;
                end
            end
            OP_ENDLP: begin
                if (empty_i) fault_o = 1'b1;
                else if (top_cnt_i != FIELD_W'(1)) begin
                    dec_o     = 1'b1;
                    next_pc_o = top_addr_i;
                end else pop_o = 1'b1;
            end
            OP_CALL: begin
                if (full_i) fault_o = 1'b1;
                else begin
                    push_o    = 1'b1;
                    next_pc_o = tgt_i;
                end
            end
            OP_RET: begin
                if (empty_i) fault_o = 1'b1;
                else begin
                    pop_o     = 1'b1;
                    next_pc_o = top_addr_i;
                end
            end
            OP_STOP: begin
                stop_o    = 1'b1;
                next_pc_o = pc_i;
            end
            default: next_pc_o = seq_pc;
        endcase
        if (fault_o) begin
            next_pc_o = pc_i;
            push_o    = 1'b0;
            pop_o     = 1'b0;
            dec_o     = 1'b0;
            stop_o    = 1'b1;
        end
    end
endmodule

// File: rtl/microseq_top.sv
// Looping micro-sequencer top: program counter, program store, next-address
// decode and loop/return stack. Assumes the program image is a parameter.
// Reset is synchronous and active low; execution restarts at address 0.
module microseq_top #(
    parameter int ROM_DEPTH   = 128,
    parameter int CTRL_W      = 20,
    parameter int FIELD_W     = 6,
    parameter int COND_W      = 8,
    parameter int STACK_DEPTH = 4,
    localparam int ADDR_W     = $clog2(ROM_DEPTH),
    localparam int WORD_W     = CTRL_W + microseq_pkg::OP_W + ADDR_W + FIELD_W,
    parameter logic [ROM_DEPTH*WORD_W-1:0] PROGRAM = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted_o,
    output logic              err_o
);
    import microseq_pkg::*;

    localparam int PTR_W = $clog2(STACK_DEPTH + 1);

    logic [ADDR_W-1:0]  pc_q;
    logic               halted_q, err_q;
    logic [WORD_W-1:0]  word;
    op_e                op;
    logic [ADDR_W-1:0]  tgt;
    logic [FIELD_W-1:0] fld;
    logic [ADDR_W-1:0]  next_pc, top_addr;
    logic [FIELD_W-1:0] top_cnt, push_cnt;
    logic               push, pop, dec, stop, fault, empty, full;
    logic [PTR_W-1:0]   stk_depth;
    logic               run;

    microseq_rom #(.DEPTH(ROM_DEPTH), .WORD_W(WORD_W), .IMAGE(PROGRAM)) u_rom (
        .addr_i (pc_q),
        .word_o (word)
    );

    // split the current word into its fields
    assign op  = op_e'(word[ADDR_W+FIELD_W +: OP_W]);
    assign tgt = word[FIELD_W +: ADDR_W];
    assign fld = word[FIELD_W-1:0];

    microseq_next #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .COND_W(COND_W)) u_next (
        .op_i       (op),
        .pc_i       (pc_q),
        .tgt_i      (tgt),
        .fld_i      (fld),
        .cond_i     (cond_i),
        .top_addr_i (top_addr),
        .top_cnt_i  (top_cnt),
        .empty_i    (empty),
        .full_i     (full),
        .next_pc_o  (next_pc),
        .push_o     (push),
        .pop_o      (pop),
        .dec_o      (dec),
        .push_cnt_o (push_cnt),
        .stop_o     (stop),
        .fault_o    (fault)
    );

    // commands only take effect while the sequencer runs
    assign run = !halted_q;

    microseq_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W), .CNT_W(FIELD_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push && run),
        .pop_i       (pop && run),
        .dec_i       (dec && run),
        .push_addr_i (pc_q + 1'b1),
        .push_cnt_i  (push_cnt),
        .top_addr_o  (top_addr),
        .top_cnt_o   (top_cnt),
        .empty_o     (empty),
        .full_o      (full),
        .depth_o     (stk_depth)
    );

    // program counter, stop state and sticky fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (run) begin
            pc_q     <= next_pc;
            halted_q <= stop;
            err_q    <= fault;
        end
    end

    // outputs: control field gated off while halted
    assign ctrl_o   = run ? word[WORD_W-1 -: CTRL_W] : '0;
    assign pc_o     = pc_q;
    assign halted_o = halted_q;
    assign err_o    = err_q;
endmodule

// File: rtl/microseq_chk.sv
// Property checker for the micro-sequencer, attached by bind below.
// Assumes the stack occupancy is brought in from the stack instance.
module microseq_chk #(
    parameter int CTRL_W      = 20,
    parameter int ADDR_W      = 7,
    parameter int STACK_DEPTH = 4,
    parameter int PTR_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl,
    input logic [ADDR_W-1:0] pc,
    input logic              halted,
    input logic              err,
    input logic [PTR_W-1:0]  depth
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (pc == '0 && !halted && !err));
    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |-> ctrl == '0);
    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(pc) && halted);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
    // R10
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> halted);
    // R6
    stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) depth <= PTR_W'(STACK_DEPTH));
endmodule

bind microseq_top microseq_chk #(
    .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH), .PTR_W(PTR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl_o),
    .pc     (pc_o),
    .halted (halted_o),
    .err    (err_o),
    .depth  (stk_depth)
);

// File: tb/tb_microseq_top.sv
module tb_microseq_top;
    localparam int WW = 36;
    localparam int DP = 128;

    // build one program word; control bits are 0x10000 | address
    function automatic logic [WW-1:0] mk(int a, logic [2:0] op, int tgt, int fld);
        return {20'(32'h10000 | a), op, 7'(tgt), 6'(fld)};
    endfunction

    function automatic logic [DP*WW-1:0] prog_main();
        logic [DP*WW-1:0] p;
        p = '0;
        p[0*WW  +: WW] = mk(0, 3'd0, 0, 0);
        p[1*WW  +: WW] = mk(1, 3'd3, 6, 3);
        p[2*WW  +: WW] = mk(2, 3'd3, 5, 2);
        p[3*WW  +: WW] = mk(3, 3'd0, 0, 0);
        p[4*WW  +: WW] = mk(4, 3'd4, 0, 0);
        p[5*WW  +: WW] = mk(5, 3'd4, 0, 0);
        p[6*WW  +: WW] = mk(6, 3'd3, 8, 0);
        p[7*WW  +: WW] = mk(7, 3'd4, 0, 0);
        p[8*WW  +: WW] = mk(8, 3'd5, 20, 0);
        p[9*WW  +: WW] = mk(9, 3'd2, 12, 0);
        p[10*WW +: WW] = mk(10, 3'd2, 12, 6'b100001);
        p[11*WW +: WW] = mk(11, 3'd0, 0, 0);
        p[12*WW +: WW] = mk(12, 3'd0, 0, 0);
        p[13*WW +: WW] = mk(13, 3'd1, 30, 0);
        p[20*WW +: WW] = mk(20, 3'd0, 0, 0);
        p[21*WW +: WW] = mk(21, 3'd6, 0, 0);
        p[30*WW +: WW] = mk(30, 3'd7, 0, 0);
        return p;
    endfunction

    function automatic logic [DP*WW-1:0] prog_deep();
        logic [DP*WW-1:0] p;
        p = '0;
        for (int i = 0; i < 5; i++) p[i*WW +: WW] = mk(i, 3'd5, i + 1, 0);
        return p;
    endfunction

    function automatic logic [DP*WW-1:0] prog_empty();
        logic [DP*WW-1:0] p;
        p = '0;
        p[0*WW +: WW] = mk(0, 3'd0, 0, 0);
        p[1*WW +: WW] = mk(1, 3'd6, 0, 0);
        return p;
    endfunction

    localparam logic [DP*WW-1:0] P_MAIN  = prog_main();
    localparam logic [DP*WW-1:0] P_DEEP  = prog_deep();
    localparam logic [DP*WW-1:0] P_EMPTY = prog_empty();

    // expected pc and halted per sample, flags all set
    localparam int NV = 30;
    localparam int EXP_PC [NV] = '{0,1, 2,3,4,3,4,5, 2,3,4,3,4,5, 2,3,4,3,4,5,
                                   6,8,20,21,9,12,13,30,30,30};
    localparam bit EXP_H  [NV] = '{0,0, 0,0,0,0,0,0, 0,0,0,0,0,0, 0,0,0,0,0,0,
                                   0,0,0,0,0,0,0,0,1,1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cond = 8'h00;
    logic [19:0] ctrl, ctrl_d, ctrl_e;
    logic [6:0] pc, pc_d, pc_e;
    logic h, e, h_d, e_d, h_e, e_e;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    microseq_top #(.PROGRAM(P_MAIN)) dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond),
        .ctrl_o(ctrl), .pc_o(pc), .halted_o(h), .err_o(e));
    microseq_top #(.PROGRAM(P_DEEP)) dut_deep (
        .clk(clk), .rst_n(rst_n), .cond_i(cond),
        .ctrl_o(ctrl_d), .pc_o(pc_d), .halted_o(h_d), .err_o(e_d));
    microseq_top #(.PROGRAM(P_EMPTY)) dut_empty (
        .clk(clk), .rst_n(rst_n), .cond_i(cond),
        .ctrl_o(ctrl_e), .pc_o(pc_e), .halted_o(h_e), .err_o(e_e));

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        // run A: all flags set; walk the vector table
        cond = 8'hFF;
        do_reset();
        // R1 reset state
        chk("R1 pc", int'(pc), 0);
        chk("R1 halted", int'(h), 0);
        chk("R1 err", int'(e), 0);
        for (int i = 0; i < NV; i++) begin
            if (i > 0) step();
            // R3 R4 R5 R6 R7 R8 R9 trace
            chk($sformatf("R7 trace pc s%0d", i), int'(pc), EXP_PC[i]);
            chk($sformatf("R9 halted s%0d", i), int'(h), int'(EXP_H[i]));
            // R2 control field follows the current word
            chk($sformatf("R2 ctrl s%0d", i), int'(ctrl),
                EXP_H[i] ? 0 : (32'h10000 | EXP_PC[i]));
            if (i == 2) begin
                // R10 underflow: return with nothing stacked
                chk("R10 empty pc", int'(pc_e), 1);
                chk("R10 empty err", int'(e_e), 1);
                chk("R10 empty halted", int'(h_e), 1);
                chk("R2 empty ctrl off", int'(ctrl_e), 0);
            end
            if (i == 4) chk("R10 deep no err yet", int'(e_d), 0);
            if (i == 5) begin
                // R10 overflow: fifth nested call
                chk("R10 deep pc", int'(pc_d), 4);
                chk("R10 deep err", int'(e_d), 1);
                chk("R10 deep halted", int'(h_d), 1);
            end
            if (i == 20) chk("R10 err sticky", int'(e_e), 1);
        end
        // run B: flags clear; branch at 9 falls through, inverted flag at 10 is taken
        cond = 8'h00;
        do_reset();
        chk("R1 reset after halt", int'(h), 0);
        chk("R1 reset clears err", int'(e_e), 0);
        for (int i = 1; i < 25; i++) step();
        chk("R8 return lands", int'(pc), 9);
        step(); chk("R5 branch not taken", int'(pc), 10);
        step(); chk("R5 inverted taken", int'(pc), 12);
        step(); chk("R3 step", int'(pc), 13);
        step(); chk("R4 jump", int'(pc), 30);
        step(); chk("R9 stop", int'(h), 1);
        step(); chk("R9 pc frozen", int'(pc), 30);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule